// File: doc/BRIEF.md
# Dual-Mode Device Interrupt Reporter

This block gathers the two kinds of device event, a used-buffer event tagged with a queue number and a configuration-change event, and reports them to the driver in one of two ways. The global message-enable input picks the way. When it is low (wired mode), each event sets a sticky bit in a small status register and a level interrupt line stays high while any bit is set. The driver reads the status word at one register offset and clears handled bits by writing a mask to the acknowledge offset.

When the message-enable input is high (message mode), the status register is frozen and acknowledge writes are dropped. Each event instead marks a vector as pending: vector 0 for a configuration change, vector n for a used-buffer event on queue n. A single request port presents one pending vector per cycle, lowest number first, to the message engine that follows. The message write and the vector address/data storage belong to that engine and are not part of this block.

Top module: `irq_event_ctrl`

## Requirements
- R1: During and just after reset the status bits are zero, `irq` is low and `msg_req` is low.
- R2: In wired mode, a pulse on `used_evt` sets status bit 0 and a pulse on `cfg_evt` sets status bit 1, visible after the next rising clock edge. Each bit stays set until it is acknowledged.
- R3: A write to offset 0x064 in wired mode clears every status bit whose position is set in the written data (bit 0 used-buffer, bit 1 configuration). Bits whose mask bit is zero are kept, and a write to any other offset leaves the status unchanged.
- R4: With `reg_rd` high and `reg_addr` at 0x060, `reg_rdata` returns the status in bits 1:0 with bits 31:2 at zero, in the same cycle. Any other read address, or `reg_rd` low, returns zero.
- R5: In wired mode `irq` is high exactly when at least one status bit is set.
- R6: When an event and an acknowledge of the same bit fall into the same cycle, the bit ends up set.
- R7: While `msg_en` is high, events do not change the status bits and acknowledge writes are ignored. The status held from before stays readable.
- R8: While `msg_en` is high, `irq` is low. A configuration-change event requests vector 0 and a used-buffer event on queue n (1 to NUM_QUEUES) requests vector n. The request appears one cycle after the event.
- R9: Several pending vectors are issued one per cycle, the lowest vector number first. An event for a vector that is already pending merges into the single outstanding request.
- R10: A used-buffer event in message mode with a queue number of 0 or above NUM_QUEUES makes no request.
- R11: After a clock edge that sees `msg_en` low, no request is pending; requests left over from message mode are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_evt | input | 1 | Configuration-change event pulse |
| used_evt | input | 1 | Used-buffer event pulse |
| used_qid | input | VEC_W | Queue number of the used-buffer event |
| msg_en | input | 1 | Global message-interrupt enable |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data |
| irq | output | 1 | Level interrupt line (wired mode) |
| msg_req | output | 1 | Message request valid |
| msg_vec | output | VEC_W | Vector number of the request |

## Verification
The critical overlap is an event and an acknowledge write for the same status bit landing on one clock edge, and in message mode a new event arriving for the vector that is being issued on that same edge. Directed cases drive a used-buffer pulse together with an acknowledge of bit 0, and repeat an event on a vector while its request is outstanding. Long random runs with dense events and acknowledges make both collisions common. The bench model lets the set win and keeps the merged vector pending for one further cycle, and every cycle's `irq`, `msg_req`, `msg_vec` and read data are compared against that model.

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl #(
  parameter int NUM_QUEUES = 8,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h060,
  parameter logic [ADDR_W-1:0] ACK_OFS  = 'h064,
  localparam int NVEC  = NUM_QUEUES + 1,
  localparam int VEC_W = $clog2(NVEC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_evt,
  input  logic              used_evt,
  input  logic [VEC_W-1:0]  used_qid,
  input  logic              msg_en,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq,
  output logic              msg_req,
  output logic [VEC_W-1:0]  msg_vec
);

  logic [1:0]      stat_q;
  logic [NVEC-1:0] pend_q, pend_set, issue;
  logic [1:0]      ack_mask;
  logic            unused_wbits;

  assign unused_wbits = ^reg_wdata[DATA_W-1:2];
  assign ack_mask = (reg_wr && reg_addr == ACK_OFS && !msg_en) ? reg_wdata[1:0] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n)      stat_q <= '0;
    else if (!msg_en) stat_q <= (stat_q & ~ack_mask) | {cfg_evt, used_evt};
  end

  always_comb begin
    pend_set    = '0;
    pend_set[0] = cfg_evt;
    for (int i = 1; i < NVEC; i++)
      if (used_evt && used_qid == VEC_W'(i)) pend_set[i] = 1'b1;
  end

  always_comb begin
    issue   = '0;
    msg_vec = '0;
    for (int i = NVEC - 1; i >= 0; i--)
      if (pend_q[i]) begin
        issue    = '0;
        issue[i] = 1'b1;
        msg_vec  = VEC_W'(i);
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !msg_en) pend_q <= '0;
    else                   pend_q <= (pend_q & ~issue) | pend_set;
  end

  assign msg_req   = |pend_q;
  assign irq       = !msg_en && (|stat_q);
  assign reg_rdata = (reg_rd && reg_addr == STAT_OFS) ? DATA_W'(stat_q) : '0;

endmodule

// File: rtl/irq_event_ctrl_chk.sv
module irq_event_ctrl_chk #(
  parameter int NUM_QUEUES = 8,
  parameter int ADDR_W = 12,
  parameter logic [ADDR_W-1:0] ACK_OFS = 'h064,
  localparam int VEC_W = $clog2(NUM_QUEUES + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_evt,
  input logic              used_evt,
  input logic              msg_en,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [1:0]        stat_q,
  input logic              irq,
  input logic              msg_req,
  input logic [VEC_W-1:0]  msg_vec
);

  AST_MSG_FREEZES_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    msg_en |=> stat_q == $past(stat_q));  // R7

  AST_USED_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_en && stat_q[0] && !(reg_wr && reg_addr == ACK_OFS)) |=> stat_q[0]);  // R2

  AST_USED_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_en && used_evt) |=> stat_q[0]);  // R6

  AST_CFG_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_en && cfg_evt) |=> stat_q[1]);  // R6

  AST_IRQ_WIRED: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_en && stat_q != 2'b00) |-> irq);  // R5

  AST_IRQ_QUIET_MSG: assert property (@(posedge clk) disable iff (!rst_n)
    msg_en |-> !irq);  // R8

  AST_VEC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    msg_req |-> msg_vec <= VEC_W'(NUM_QUEUES));  // R9

  AST_DROP_ON_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_en |=> !msg_req);  // R11

endmodule

bind irq_event_ctrl irq_event_ctrl_chk #(
  .NUM_QUEUES(NUM_QUEUES), .ADDR_W(ADDR_W), .ACK_OFS(ACK_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_evt(cfg_evt), .used_evt(used_evt),
  .msg_en(msg_en), .reg_wr(reg_wr), .reg_addr(reg_addr), .stat_q(stat_q),
  .irq(irq), .msg_req(msg_req), .msg_vec(msg_vec)
);

// File: tb/irq_event_ctrl_test.sv
module irq_event_ctrl_test;
  localparam int NQ = 8;
  localparam int VW = $clog2(NQ + 1);

  logic clk = 0, rst_n = 0, cfg_evt = 0, used_evt = 0, msg_en = 0, reg_wr = 0, reg_rd = 0;
  logic [VW-1:0] used_qid = '0;
  logic [11:0]   reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  wire  [31:0]   reg_rdata;
  wire           irq, msg_req;
  wire  [VW-1:0] msg_vec;

  irq_event_ctrl #(.NUM_QUEUES(NQ)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_evt(cfg_evt), .used_evt(used_evt), .used_qid(used_qid),
    .msg_en(msg_en), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq), .msg_req(msg_req), .msg_vec(msg_vec));

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  logic [1:0]  m_stat = '0;
  logic [NQ:0] m_pend = '0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int low_vec(logic [NQ:0] p);
    for (int i = 0; i <= NQ; i++) if (p[i]) return i;
    return 0;
  endfunction

  task automatic model_edge();
    logic [NQ:0] nxt;
    logic [1:0]  ack;
    if (!rst_n) begin
      m_stat = '0; m_pend = '0;
    end else if (msg_en) begin
      nxt = m_pend;
      if (|m_pend) nxt[low_vec(m_pend)] = 1'b0;
      if (cfg_evt) nxt[0] = 1'b1;
      if (used_evt && used_qid >= 1 && int'(used_qid) <= NQ) nxt[used_qid] = 1'b1;
      m_pend = nxt;
    end else begin
      ack = (reg_wr && reg_addr == 12'h064) ? reg_wdata[1:0] : 2'b00;
      m_stat = (m_stat & ~ack) | {cfg_evt, used_evt};
      m_pend = '0;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk("R5 irq", 32'(irq), 32'(!msg_en && (|m_stat)));
    chk("R9 msg_req", 32'(msg_req), 32'(|m_pend));
    if (|m_pend) chk("R9 msg_vec", 32'(msg_vec), 32'(low_vec(m_pend)));
    chk("R4 rdata", reg_rdata, (reg_rd && reg_addr == 12'h060) ? {30'b0, m_stat} : 32'h0);
  endtask

  task automatic idle();
    cfg_evt = 0; used_evt = 0; used_qid = '0; reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic read_stat(string req, logic [31:0] exp);
    reg_rd = 1; reg_addr = 12'h060; #1;
    chk(req, reg_rdata, exp);
    reg_rd = 0; reg_addr = '0;
  endtask

  task automatic ack(logic [31:0] m, logic [11:0] a);
    reg_wr = 1; reg_addr = a; reg_wdata = m; tick(); idle();
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    repeat (3) tick();
    chk("R1 irq in reset", 32'(irq), 0);
    chk("R1 msg_req in reset", 32'(msg_req), 0);
    rst_n = 1;
    tick();
    read_stat("R1 status after reset", 0);

    used_evt = 1; tick(); idle(); tick(); tick();
    read_stat("R2 used bit sticky", 32'h1);
    cfg_evt = 1; tick(); idle();
    read_stat("R2 config bit", 32'h3);
    chk("R5 irq with status", 32'(irq), 1);
    reg_rd = 1; reg_addr = 12'h068; #1; chk("R4 other address reads zero", reg_rdata, 0); idle();

    ack(32'hFFFF_FFF1, 12'h064);
    read_stat("R3 ack bit0 keeps bit1", 32'h2);
    ack(32'h2, 12'h068);
    read_stat("R3 wrong offset no effect", 32'h2);
    ack(32'h2, 12'h064);
    read_stat("R3 ack bit1", 0);
    chk("R5 irq low when clear", 32'(irq), 0);

    used_evt = 1; reg_wr = 1; reg_addr = 12'h064; reg_wdata = 32'h1; tick(); idle();
    read_stat("R6 event beats ack", 32'h1);

    msg_en = 1; cfg_evt = 1; reg_wr = 1; reg_addr = 12'h064; reg_wdata = 32'h3; tick(); idle();
    read_stat("R7 status frozen in message mode", 32'h1);
    chk("R8 irq quiet in message mode", 32'(irq), 0);
    chk("R8 config requests vector 0", {31'b0, msg_req} | (32'(msg_vec) << 4), 32'h1);
    used_evt = 1; used_qid = 5; tick(); idle();
    chk("R8 queue 5 requests vector 5", 32'(msg_vec), 5);
    tick();
    chk("R8 request retires", 32'(msg_req), 0);

    cfg_evt = 1; used_evt = 1; used_qid = 3; tick(); idle();
    chk("R9 lowest first", 32'(msg_vec), 0);
    used_evt = 1; used_qid = 7; tick(); idle();
    chk("R9 then queue 3", 32'(msg_vec), 3);
    tick();
    chk("R9 then queue 7", 32'(msg_vec), 7);
    tick();
    chk("R9 drained", 32'(msg_req), 0);
    used_evt = 1; used_qid = 2; tick(); tick(); idle();
    chk("R9 repeat merges", 32'(msg_vec), 2);
    tick();
    chk("R9 merged retires", 32'(msg_req), 0);

    used_evt = 1; used_qid = 0; tick(); idle();
    chk("R10 queue 0 ignored", 32'(msg_req), 0);
    used_evt = 1; used_qid = 9; tick(); idle();
    chk("R10 queue 9 ignored", 32'(msg_req), 0);

    used_evt = 1; used_qid = 4; cfg_evt = 1; tick(); idle();
    msg_en = 0; tick();
    chk("R11 pending dropped", 32'(msg_req), 0);
    read_stat("R7 status kept across modes", 32'h1);
    ack(32'h3, 12'h064);

    for (int k = 0; k < 4000; k++) begin
      if ($urandom_range(63) == 0) msg_en = ~msg_en;
      used_evt  = ($urandom_range(9) < 3);
      cfg_evt   = ($urandom_range(9) < 2);
      used_qid  = VW'($urandom_range(15));
      reg_wr    = ($urandom_range(3) == 0);
      reg_addr  = ($urandom_range(9) < 7) ? 12'h064 : 12'($urandom_range(255));
      reg_wdata = $urandom;
      reg_rd    = $urandom_range(1);
      if ($urandom_range(1) == 0) reg_addr = 12'h060;
      tick();
    end

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule